// File: doc/BRIEF.md
# I2C Write-Only Bus Master

This block drives a two-wire I2C bus as the only master and performs write transfers. The caller presents a 7-bit target address, a byte count, a divider setting and a repeated-start choice, then pulses a start request. The block puts a START on the bus and sends the address byte with the direction bit set to write. It then sends the requested number of data bytes and checks the target's acknowledge after every byte.

Both lines are open-drain. The block never drives a line high. It only asserts a pull-low enable per line, and it reads the resolved line levels back. Data bytes come from an input that the block samples whenever it needs the next byte. A one-cycle pulse marks each byte taken, so the caller can advance a pointer or FIFO.

A transfer normally ends with a STOP. If a transfer asks to be chained, it ends with SCL held low instead and the bus stays owned. The next request then opens with a repeated START.

Top module: `i2cw_master`

## Requirements
- R1: A fresh START pulls SDA low while SCL is released. SCL is pulled low one quarter-period later.
- R2: The first byte is `{addr_i, 1'b0}` (write = 0), sent most significant bit first over eight SCL pulses.
- R3: Apart from START and STOP, SDA changes only while SCL is held low. A new bit is placed one quarter-period after SCL falls, and SCL is released one quarter-period later.
- R4: In the ninth SCL pulse of each byte, SDA is released. The target's acknowledge is taken as SDA low at the end of the first quarter of the SCL high phase.
- R5: A missing acknowledge, after the address or after any data byte, sets `nack_o` and goes straight to STOP. No later byte is taken or sent. `nack_o` stays set until the next request is accepted.
- R6: After an acknowledged byte, while data bytes remain, the block samples `data_i` at the falling SCL edge of the ninth pulse and pulses `data_pop_o` for one cycle. It sends exactly `len_i` data bytes, most significant bit first.
- R7: A STOP pulls SDA low while SCL is low, then releases SCL, and one quarter-period later releases SDA.
- R8: With `rstart_i` set and all bytes acknowledged, the transfer ends with SCL held low and SDA released. A request accepted in that state first releases SCL (one quarter-period), then issues the START of R1.
- R9: Every quarter-period lasts `div_i + 1` clock cycles. `div_i` is captured when the request is accepted.
- R10: `busy_o` rises in the cycle after a request is accepted. It falls in the cycle where `done_o` pulses high for exactly one cycle. A `start_i` seen while busy is ignored.
- R11: After reset both pull-low enables are off, and `busy_o`, `done_o`, `nack_o` and `data_pop_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, accepted when not busy |
| addr_i | input | 7 | Target address |
| len_i | input | LEN_W | Number of data bytes after the address |
| rstart_i | input | 1 | End with bus held for a repeated START |
| div_i | input | DIV_W | Quarter-period length minus one, in clocks |
| data_i | input | 8 | Next data byte to send |
| data_pop_o | output | 1 | One-cycle pulse: `data_i` was taken |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| nack_o | output | 1 | Sticky missing-acknowledge flag |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| scl_i | input | 1 | Resolved SCL level |
| sda_i | input | 1 | Resolved SDA level |

## Verification
A wrong quarter counter or bit counter shows at the ports within one quarter-period. It appears as an SCL edge out of place or an extra or missing SCL pulse in the very byte where it goes wrong. A corrupted shifter shows as a wrong SDA level in the next SCL-low quarter. A mis-sampled acknowledge shows as `nack_o`, `data_pop_o` or the STOP sequence diverging by the falling SCL edge of that ninth pulse. The bench therefore compares both pull-low enables and every status output against a per-cycle expected trace on every clock, so any such fault surfaces in the cycle it occurs.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
    localparam int BYTE_W = 8;
    localparam int ADR_W  = 7;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RSU,
        S_START,
        S_BIT,
        S_ACK,
        S_STOP
    } state_e;
endpackage

// File: rtl/i2cw_tick.sv
module i2cw_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == div_i);
        cnt_d  = cnt_q + DIV_W'(1);
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2cw_shift.sv
module i2cw_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic [W-1:0] data_i,
    output logic         msb_o
);
    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load_i)       sr_d = data_i;
        else if (shift_i) sr_d = {sr_q[W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign msb_o = sr_q[W-1];
endmodule

// File: rtl/i2cw_master.sv
module i2cw_master
    import i2cw_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADR_W-1:0]  addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              rstart_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic              data_pop_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              nack_o,
    output logic              scl_oe_o,
    output logic              sda_oe_o,
    input  logic              scl_i,
    input  logic              sda_i
);
    localparam int BCNT_W = $clog2(BYTE_W);

    typedef struct packed {
        state_e             st;
        logic [1:0]         qtr;
        logic [BCNT_W-1:0]  bitn;
        logic [LEN_W-1:0]   left;
        logic [ADR_W-1:0]   addr;
        logic               rstart;
        logic [DIV_W-1:0]   div;
        logic               held;
        logic               ackok;
        logic               scl_oe;
        logic               sda_oe;
        logic               nack;
        logic               done;
        logic               pop;
    } ctl_t;

    ctl_t              d, q;
    logic              tick;
    logic              msb;
    logic              ld;
    logic              sh;
    logic [BYTE_W-1:0] ld_val;

    i2cw_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (q.st != S_IDLE),
        .div_i (q.div),
        .tick_o(tick)
    );

    i2cw_shift #(.W(BYTE_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ld),
        .shift_i(sh),
        .data_i (ld_val),
        .msb_o  (msb)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.pop  = 1'b0;
        ld     = 1'b0;
        sh     = 1'b0;
        ld_val = data_i;
        unique case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.addr   = addr_i;
                    d.left   = len_i;
                    d.rstart = rstart_i;
                    d.div    = div_i;
                    d.nack   = 1'b0;
                    d.qtr    = '0;
                    if (q.held) begin
                        d.st     = S_RSU;
                        d.sda_oe = 1'b0;
                    end else begin
                        d.st     = S_START;
                        d.sda_oe = 1'b1;
                    end
                end
            end
            S_RSU: begin
                if (tick) begin
                    if (q.qtr == 2'd0) begin
                        d.scl_oe = 1'b0;
                        d.qtr    = 2'd1;
                    end else begin
                        d.st     = S_START;
                        d.qtr    = '0;
                        d.sda_oe = 1'b1;
                    end
                end
            end
            S_START: begin
                if (tick) begin
                    if (q.qtr == 2'd0) begin
                        d.scl_oe = 1'b1;
                        d.qtr    = 2'd1;
                    end else begin
                        ld     = 1'b1;
                        ld_val = {q.addr, 1'b0};
                        d.st   = S_BIT;
                        d.qtr  = '0;
                        d.bitn = '0;
                        d.held = 1'b0;
                    end
                end
            end
            S_BIT: begin
                if (tick) begin
                    d.qtr = q.qtr + 2'd1;
                    unique case (q.qtr)
                        2'd0: d.sda_oe = ~msb;
                        2'd1: d.scl_oe = 1'b0;
                        2'd2: ;
                        2'd3: begin
                            d.scl_oe = 1'b1;
                            sh       = 1'b1;
                            if (q.bitn == BCNT_W'(BYTE_W - 1)) d.st = S_ACK;
                            else d.bitn = q.bitn + BCNT_W'(1);
                        end
                        default: ;
                    endcase
                end
            end
            S_ACK: begin
                if (tick) begin
                    d.qtr = q.qtr + 2'd1;
                    unique case (q.qtr)
                        2'd0: d.sda_oe = 1'b0;
                        2'd1: d.scl_oe = 1'b0;
                        2'd2: d.ackok  = scl_i & ~sda_i;
                        2'd3: begin
                            d.scl_oe = 1'b1;
                            if (!q.ackok) begin
                                d.nack = 1'b1;
                                d.st   = S_STOP;
                            end else if (q.left != '0) begin
                                ld     = 1'b1;
                                d.pop  = 1'b1;
                                d.left = q.left - LEN_W'(1);
                                d.bitn = '0;
                                d.st   = S_BIT;
                            end else if (q.rstart) begin
                                d.st   = S_IDLE;
                                d.held = 1'b1;
                                d.done = 1'b1;
                            end else begin
                                d.st = S_STOP;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            S_STOP: begin
                if (tick) begin
                    d.qtr = q.qtr + 2'd1;
                    unique case (q.qtr)
                        2'd0: d.sda_oe = 1'b1;
                        2'd1: d.scl_oe = 1'b0;
                        2'd2: d.sda_oe = 1'b0;
                        2'd3: begin
                            d.st   = S_IDLE;
                            d.done = 1'b1;
                            d.held = 1'b0;
                        end
                        default: ;
                    endcase
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy_o     = (q.st != S_IDLE);
    assign done_o     = q.done;
    assign nack_o     = q.nack;
    assign data_pop_o = q.pop;
    assign scl_oe_o   = q.scl_oe;
    assign sda_oe_o   = q.sda_oe;
endmodule

// File: rtl/i2cw_master_chk.sv
module i2cw_master_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_oe,
    input logic sda_oe,
    input logic busy,
    input logic done,
    input logic nack,
    input logic pop
);
    // R1: a fresh START opens with SDA pulled low and SCL still released
    a_r1_start_order: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !$past(scl_oe)) |-> (sda_oe && !scl_oe));

    // R8: a chained request opens with SCL still held and SDA released
    a_r8_restart_setup: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(scl_oe)) |-> (scl_oe && !sda_oe));

    // R3: an SDA change while SCL stays high happens only inside a transfer (START/STOP)
    a_r3_sda_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((sda_oe != $past(sda_oe)) && !scl_oe && !$past(scl_oe)) |-> busy);

    // R5: a missing acknowledge enters STOP with SCL low and SDA released
    a_r5_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack) |-> (busy && scl_oe && !sda_oe));

    // R6: bytes are taken only during a healthy transfer, with SCL low
    a_r6_pop_ok: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (busy && !nack && scl_oe));

    // R10: done is one cycle wide and coincides with busy low
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R11: an idle bus that is not held has both lines released
    a_r11_idle_free: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !scl_oe) |-> !sda_oe);
endmodule

bind i2cw_master i2cw_master_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_oe(scl_oe_o),
    .sda_oe(sda_oe_o),
    .busy  (busy_o),
    .done  (done_o),
    .nack  (nack_o),
    .pop   (data_pop_o)
);

// File: tb/sim_i2cw_master.sv
module sim_i2cw_master;
    localparam int DIV_W = 8;
    localparam int LEN_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk; // 50 MHz

    logic             start_i = 1'b0;
    logic [6:0]       addr_i = '0;
    logic [LEN_W-1:0] len_i = '0;
    logic             rstart_i = 1'b0;
    logic [DIV_W-1:0] div_i = '0;
    logic [7:0]       data_i;
    logic             pop, busy, done, nack, scl_oe, sda_oe;
    logic             scl_line, sda_line;
    logic             tgt_low = 1'b0;

    logic [7:0] mem [0:15];
    int         idx = 0;
    assign data_i   = mem[idx];
    assign scl_line = ~scl_oe;
    assign sda_line = ~(sda_oe | tgt_low);

    i2cw_master #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .len_i(len_i), .rstart_i(rstart_i), .div_i(div_i), .data_i(data_i),
        .data_pop_o(pop), .busy_o(busy), .done_o(done), .nack_o(nack),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .scl_i(scl_line), .sda_i(sda_line)
    );

    typedef struct {
        bit    scl;
        bit    sda;
        bit    tgt;
        bit    busy;
        bit    done;
        bit    pop;
        bit    nack;
        string tag;
    } exp_t;

    exp_t eq[$];
    exp_t last;
    int   checks = 0;
    int   errs = 0;
    bit   m_sda;
    bit   m_nack;
    int   qlen;

    task automatic chk(string tag, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one quarter-period of expected line levels
    task automatic push(bit scl, bit sda, bit tgt, bit pp, string tag);
        for (int i = 0; i < qlen; i++) begin
            exp_t e;
            e.scl = scl; e.sda = sda; e.tgt = tgt; e.busy = 1'b1; e.done = 1'b0;
            e.pop = pp && (i == 0); e.nack = m_nack; e.tag = tag;
            eq.push_back(e);
        end
        m_sda = sda;
    endtask

    task automatic step();
        exp_t e;
        @(negedge clk);
        if (eq.size() > 0) begin
            e = eq.pop_front();
            last = e;
            last.done = 1'b0;
            last.pop = 1'b0;
        end else begin
            e = last;
        end
        chk(e.tag, scl_oe, e.scl, "scl_oe");
        chk(e.tag, sda_oe, e.sda, "sda_oe");
        chk("R10", busy, e.busy, "busy");
        chk("R10", done, e.done, "done");
        chk("R6", pop, e.pop, "data_pop");
        chk("R5", nack, e.nack, "nack");
        tgt_low = e.tgt;
        if (pop) idx++;
    endtask

    task automatic xfer(bit [6:0] a, int n, int base, int ackmask, bit rs, int dv,
                        bit from_held, bit poke);
        exp_t f;
        int   cnt;
        qlen   = dv + 1;
        m_nack = 1'b0;
        idx    = base;
        addr_i = a; len_i = LEN_W'(n); rstart_i = rs; div_i = DIV_W'(dv);
        start_i = 1'b1;
        if (from_held) begin
            push(1, 0, 0, 0, "R8");
            push(0, 0, 0, 0, "R8");
        end
        push(0, 1, 0, 0, "R1 R9");
        push(1, 1, 0, 0, "R1");
        for (int k = -1; k < n; k++) begin
            logic [7:0] v;
            bit         ack;
            string      tg;
            v  = (k < 0) ? {a, 1'b0} : mem[base + k];
            tg = (k < 0) ? "R2 R3" : "R6 R3";
            for (int b = 7; b >= 0; b--) begin
                push(1, m_sda, 0, (k >= 0) && (b == 7), tg);
                push(1, ~v[b], 0, 0, tg);
                push(0, ~v[b], 0, 0, tg);
                push(0, ~v[b], 0, 0, tg);
            end
            ack = ackmask[k + 1];
            push(1, m_sda, 0, 0, "R4");
            push(1, 0, ack, 0, "R4");
            push(0, 0, ack, 0, "R4");
            push(0, 0, ack, 0, "R4");
            if (!ack) begin
                m_nack = 1'b1;
                break;
            end
        end
        if (rs && !m_nack) begin
            f.scl = 1; f.sda = 0; f.tag = "R8";
        end else begin
            push(1, 0, 0, 0, "R7");
            push(1, 1, 0, 0, "R7");
            push(0, 1, 0, 0, "R7");
            push(0, 0, 0, 0, "R7");
            f.scl = 0; f.sda = 0; f.tag = "R7";
        end
        f.tgt = 0; f.busy = 0; f.done = 1; f.pop = 0; f.nack = m_nack;
        eq.push_back(f);
        step();
        start_i = 1'b0;
        cnt = 0;
        while (eq.size() > 0) begin
            step();
            // R10: a request while busy must leave the trace unchanged
            if (poke && cnt == 20) begin start_i = 1'b1; addr_i = 7'h0F; end
            if (poke && cnt == 21) start_i = 1'b0;
            cnt++;
        end
        repeat (3) step();
    endtask

    initial begin
        #3000000;
        errs++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'(i * 37 + 5);
        mem[0] = 8'hA5; mem[1] = 8'h3C; mem[4] = 8'h81; mem[8] = 8'h00;
        last.scl = 0; last.sda = 0; last.tgt = 0; last.busy = 0;
        last.done = 0; last.pop = 0; last.nack = 0; last.tag = "R11";
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", scl_oe, 1'b0, "scl_oe");
        chk("R11", sda_oe, 1'b0, "sda_oe");
        chk("R11", busy, 1'b0, "busy");
        chk("R11", done, 1'b0, "done");
        chk("R11", nack, 1'b0, "nack");
        chk("R11", pop, 1'b0, "data_pop");
        rst_n = 1'b1;
        repeat (2) step();
        // two data bytes, all acknowledged, STOP
        xfer(7'h5A, 2, 0, 'h7, 0, 1, 0, 0);
        // address only, chained (R8)
        xfer(7'h23, 0, 0, 'h1, 1, 0, 0, 0);
        repeat (5) step();
        // repeated START from held bus, one byte, ignored request while busy (R10), R9 div 2
        xfer(7'h7F, 1, 4, 'h3, 0, 2, 1, 1);
        // address not acknowledged (R5)
        xfer(7'h11, 3, 0, 'h0, 0, 1, 0, 0);
        // second data byte not acknowledged (R5, R6)
        xfer(7'h40, 3, 0, 'h3, 0, 1, 0, 0);
        // new request clears nack, slow divider (R9)
        xfer(7'h00, 1, 8, 'h3, 0, 3, 0, 0);
        // nack at end of chained transfer still stops (R5 over R8)
        xfer(7'h35, 1, 2, 'h1, 1, 0, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end
endmodule